// File: doc/BRIEF.md
# Width-Expanded Dual-Port Memory with Shared Arbitration

This block is a true dual-port memory, 32 bits wide, built from two 16-bit slices that share one address space. Ports A and B each have an active-low chip select, an active-low output enable, an address, write data, and four active-low byte-lane write strobes. Each strobe writes one byte of the 32-bit word, so a port can write some lanes of a word and read the others in the same cycle. Reads are registered. Data returns one cycle after the address is presented, and a per-lane valid flag takes the place of tri-state control.

Only the low (master) slice holds a contention arbiter. When both ports select the same address, the arbiter drives the losing port's busy flag low and blocks that port's writes to the master lanes. The same busy decision goes with the write to the high (slave) slice, so both slices block the same port. A second arbiter could reach the opposite decision and cause a lock-out where both sides are busy, and sharing one decision prevents this. Writes to the slave slice are issued `ARB_DLY` clock cycles after the strobe, so the busy decision has settled before a slave write can start.

The read side has no back-pressure. A read presented in cycle t always returns in cycle t+1, and the busy flag is the only means of stalling a port. A port that loses arbitration holds its strobe and its address until busy_n returns high, and the write then completes.

Top module: `dpm_wide_top`

## Requirements
- R1: Strobe `x_we_n[k]` low with `x_cs_n` low and no busy writes bits 8k+7:8k of the addressed word at that clock edge, for master lanes k=0 and k=1. Lanes whose strobe is high keep their contents.
- R2: A read lane k is a lane with `x_cs_n` low, `x_oe_n` low and `x_we_n[k]` high. One cycle later, `x_rvalid[k]` is 1 and the lane returns the word's content as it stood before that cycle's writes. Any other lane returns `x_rvalid[k]`=0 and zero data.
- R3: With `x_cs_n` high, the port writes nothing, its `x_rvalid` is 0 on the next cycle, and it causes no busy flag on either port.
- R4: When both ports have chip select low on the same address, exactly one `busy_n` is low. The two busy flags are never low together, and both are high whenever the addresses differ or a port is deselected.
- R5: If contention continues on unchanged addresses, the winner of the previous cycle keeps winning. Otherwise port B wins only if it was selected on that address in the previous cycle and port A was not. In every other case, including simultaneous arrival, port A wins.
- R6: A write from a port whose `busy_n` is low leaves both master lanes of the word unchanged in that cycle.
- R7: Slave lanes (k=2,3) are written `ARB_DLY` cycles after the strobe cycle, using the address and data captured in that cycle. A read issued before then returns the old slave data.
- R8: A slave write is dropped if its port was busy in the strobe cycle. A strobe that is held until busy clears completes in both slices.
- R9: If both ports write the same address in the same cycle, only the winner's data is stored, in all four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A read enable, active low |
| a_addr | input | AW | Port A word address |
| a_we_n | input | 4 | Port A byte-lane write strobes, active low |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A registered read data |
| a_rvalid | output | 4 | Port A per-lane read valid |
| a_busy_n | output | 1 | Port A lost arbitration, active low |
| b_cs_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B read enable, active low |
| b_addr | input | AW | Port B word address |
| b_we_n | input | 4 | Port B byte-lane write strobes, active low |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B registered read data |
| b_rvalid | output | 4 | Port B per-lane read valid |
| b_busy_n | output | 1 | Port B lost arbitration, active low |

## Verification
The bench builds the block with `AW`=4 and `ARB_DLY`=2. Sixteen words let random traffic on a four-address window collide often, which exercises incumbent wins, contention that persists across cycles, and simultaneous arrival. A two-stage slave delay opens a window in which one word has fresh master lanes and stale slave lanes, and in which a busy flag can clear while a blocked slave write is still in flight.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int BYTE_W = 8;
  localparam int SLICE_LANES = 2;

  typedef enum logic {
    WIN_A = 1'b0,
    WIN_B = 1'b1
  } dpm_win_e;
endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_a,
  input  logic          act_b,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          busy_a,
  output logic          busy_b
);
  import dpm_pkg::*;

  logic          p_act_a, p_act_b, p_match;
  logic [AW-1:0] p_addr_a, p_addr_b;
  dpm_win_e      p_win;

  logic match, inc_a, inc_b, keep, win_b;

  always_comb begin
    match  = act_a && act_b && (addr_a == addr_b);
    inc_a  = p_act_a && (p_addr_a == addr_a);
    inc_b  = p_act_b && (p_addr_b == addr_b);
    keep   = p_match && inc_a && inc_b;
    win_b  = keep ? (p_win == WIN_B) : (inc_b && !inc_a);
    busy_a = match && win_b;
    busy_b = match && !win_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_act_a  <= 1'b0;
      p_act_b  <= 1'b0;
      p_addr_a <= '0;
      p_addr_b <= '0;
      p_match  <= 1'b0;
      p_win    <= WIN_A;
    end else begin
      p_act_a  <= act_a;
      p_act_b  <= act_b;
      p_addr_a <= addr_a;
      p_addr_b <= addr_b;
      p_match  <= match;
      p_win    <= (match && win_b) ? WIN_B : WIN_A;
    end
  end
endmodule

// File: rtl/dpm_delay.sv
module dpm_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/dpm_slice.sv
module dpm_slice #(
  parameter int AW     = 11,
  parameter int LANES  = dpm_pkg::SLICE_LANES,
  parameter int LANE_W = dpm_pkg::BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         a_wr_addr,
  input  logic [LANES-1:0]      a_we,
  input  logic [LANES*LANE_W-1:0] a_wdata,
  input  logic [AW-1:0]         a_rd_addr,
  input  logic [LANES-1:0]      a_rd,
  output logic [LANES*LANE_W-1:0] a_rdata,
  output logic [LANES-1:0]      a_rvalid,
  input  logic [AW-1:0]         b_wr_addr,
  input  logic [LANES-1:0]      b_we,
  input  logic [LANES*LANE_W-1:0] b_wdata,
  input  logic [AW-1:0]         b_rd_addr,
  input  logic [LANES-1:0]      b_rd,
  output logic [LANES*LANE_W-1:0] b_rdata,
  output logic [LANES-1:0]      b_rvalid
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (a_we[l]) mem[a_wr_addr] <= a_wdata[l*LANE_W +: LANE_W];
      if (b_we[l]) mem[b_wr_addr] <= b_wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_rdata[l*LANE_W +: LANE_W] <= '0;
        b_rdata[l*LANE_W +: LANE_W] <= '0;
        a_rvalid[l] <= 1'b0;
        b_rvalid[l] <= 1'b0;
      end else begin
        a_rdata[l*LANE_W +: LANE_W] <= a_rd[l] ? mem[a_rd_addr] : '0;
        b_rdata[l*LANE_W +: LANE_W] <= b_rd[l] ? mem[b_rd_addr] : '0;
        a_rvalid[l] <= a_rd[l];
        b_rvalid[l] <= b_rd[l];
      end
    end
  end
endmodule

// File: rtl/dpm_wide_top.sv
module dpm_wide_top #(
  parameter int AW      = 11,
  parameter int ARB_DLY = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [3:0]    a_we_n,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  output logic [3:0]    a_rvalid,
  output logic          a_busy_n,
  input  logic          b_cs_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [3:0]    b_we_n,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata,
  output logic [3:0]    b_rvalid,
  output logic          b_busy_n
);
  import dpm_pkg::*;

  localparam int NL     = SLICE_LANES;
  localparam int SW     = NL * BYTE_W;
  localparam int REQ_W  = 1 + NL + AW + SW;

  logic act_a, act_b, busy_a, busy_b;
  logic [2*NL-1:0] rd_a, rd_b;
  logic [NL-1:0]   mwe_a, mwe_b, swe_a, swe_b;

  assign act_a = !a_cs_n;
  assign act_b = !b_cs_n;

  dpm_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .act_a(act_a), .act_b(act_b),
    .addr_a(a_addr), .addr_b(b_addr),
    .busy_a(busy_a), .busy_b(busy_b)
  );

  assign a_busy_n = !busy_a;
  assign b_busy_n = !busy_b;

  assign rd_a  = {2*NL{act_a && !a_oe_n}} & a_we_n;
  assign rd_b  = {2*NL{act_b && !b_oe_n}} & b_we_n;
  assign mwe_a = {NL{act_a && !busy_a}} & ~a_we_n[NL-1:0];
  assign mwe_b = {NL{act_b && !busy_b}} & ~b_we_n[NL-1:0];

  // Slave requests carry the busy decision of their strobe cycle.
  logic [REQ_W-1:0] req_a, req_b, dreq_a, dreq_b;
  logic             dbusy_a, dbusy_b;
  logic [NL-1:0]    dstb_a, dstb_b;
  logic [AW-1:0]    daddr_a, daddr_b;
  logic [SW-1:0]    ddata_a, ddata_b;

  assign req_a = {busy_a, {NL{act_a}} & ~a_we_n[2*NL-1:NL], a_addr, a_wdata[2*SW-1:SW]};
  assign req_b = {busy_b, {NL{act_b}} & ~b_we_n[2*NL-1:NL], b_addr, b_wdata[2*SW-1:SW]};

  dpm_delay #(.W(REQ_W), .DEPTH(ARB_DLY)) u_dly_a (
    .clk(clk), .rst_n(rst_n), .din(req_a), .dout(dreq_a));
  dpm_delay #(.W(REQ_W), .DEPTH(ARB_DLY)) u_dly_b (
    .clk(clk), .rst_n(rst_n), .din(req_b), .dout(dreq_b));

  assign {dbusy_a, dstb_a, daddr_a, ddata_a} = dreq_a;
  assign {dbusy_b, dstb_b, daddr_b, ddata_b} = dreq_b;
  assign swe_a = dstb_a & ~{NL{dbusy_a}};
  assign swe_b = dstb_b & ~{NL{dbusy_b}};

  dpm_slice #(.AW(AW)) u_master (
    .clk(clk), .rst_n(rst_n),
    .a_wr_addr(a_addr), .a_we(mwe_a), .a_wdata(a_wdata[SW-1:0]),
    .a_rd_addr(a_addr), .a_rd(rd_a[NL-1:0]),
    .a_rdata(a_rdata[SW-1:0]), .a_rvalid(a_rvalid[NL-1:0]),
    .b_wr_addr(b_addr), .b_we(mwe_b), .b_wdata(b_wdata[SW-1:0]),
    .b_rd_addr(b_addr), .b_rd(rd_b[NL-1:0]),
    .b_rdata(b_rdata[SW-1:0]), .b_rvalid(b_rvalid[NL-1:0])
  );

  dpm_slice #(.AW(AW)) u_slave (
    .clk(clk), .rst_n(rst_n),
    .a_wr_addr(daddr_a), .a_we(swe_a), .a_wdata(ddata_a),
    .a_rd_addr(a_addr), .a_rd(rd_a[2*NL-1:NL]),
    .a_rdata(a_rdata[2*SW-1:SW]), .a_rvalid(a_rvalid[2*NL-1:NL]),
    .b_wr_addr(daddr_b), .b_we(swe_b), .b_wdata(ddata_b),
    .b_rd_addr(b_addr), .b_rd(rd_b[2*NL-1:NL]),
    .b_rdata(b_rdata[2*SW-1:SW]), .b_rvalid(b_rvalid[2*NL-1:NL])
  );
endmodule

// File: rtl/dpm_wide_checker.sv
module dpm_wide_checker #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_cs_n,
  input logic          a_oe_n,
  input logic [AW-1:0] a_addr,
  input logic [3:0]    a_we_n,
  input logic [31:0]   a_rdata,
  input logic [3:0]    a_rvalid,
  input logic          a_busy_n,
  input logic          b_cs_n,
  input logic [AW-1:0] b_addr,
  input logic          b_busy_n
);
  logic cont;
  assign cont = !a_cs_n && !b_cs_n && (a_addr == b_addr);

  p_busy_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!a_busy_n && !b_busy_n));

  p_one_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cont |-> (a_busy_n != b_busy_n));

  p_no_spurious_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_busy_n || !b_busy_n) |-> cont);

  p_keep_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> (!(cont && $stable(a_addr) && $stable(b_addr)) || $stable(a_busy_n)));

  p_idle_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_cs_n |=> (a_rvalid == 4'b0000));

  p_read_lane_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_oe_n && a_we_n[0]) |=> a_rvalid[0]);

  p_write_lane_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_we_n[3]) |=> !a_rvalid[3]);

  p_invalid_lane_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rvalid[1] |-> (a_rdata[15:8] == 8'h00));
endmodule

bind dpm_wide_top dpm_wide_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_oe_n(a_oe_n), .a_addr(a_addr), .a_we_n(a_we_n),
  .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_busy_n(a_busy_n),
  .b_cs_n(b_cs_n), .b_addr(b_addr), .b_busy_n(b_busy_n)
);

// File: tb/tb_dpm_wide_top.sv
module tb_dpm_wide_top;
  localparam int AW = 4;
  localparam int D  = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          a_cs_n = 1, a_oe_n = 1, b_cs_n = 1, b_oe_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [3:0]    a_we_n = 4'hF, b_we_n = 4'hF;
  logic [31:0]   a_wdata = '0, b_wdata = '0;
  logic [31:0]   a_rdata, b_rdata;
  logic [3:0]    a_rvalid, b_rvalid;
  logic          a_busy_n, b_busy_n;

  dpm_wide_top #(.AW(AW), .ARB_DLY(D)) dut (.*);

  int checks = 0, fails = 0;
  string tag = "R2";

  // Reference state
  logic [15:0] mm [NW];
  logic [15:0] sm [NW];
  typedef struct packed { logic busy; logic [1:0] we; logic [AW-1:0] addr; logic [15:0] data; } pw_t;
  pw_t pa [D];
  pw_t pb [D];
  logic h_act_a = 0, h_act_b = 0, h_match = 0, h_win_b = 0;
  logic [AW-1:0] h_addr_a = '0, h_addr_b = '0;
  logic [31:0] exp_ra = '0, exp_rb = '0;
  logic [3:0]  exp_va = '0, exp_vb = '0;

  function automatic logic [31:0] lane_mask(input logic [3:0] v);
    return {{8{v[3]}}, {8{v[2]}}, {8{v[1]}}, {8{v[0]}}};
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic apply_slave(input pw_t p);
    for (int k = 0; k < 2; k++)
      if (p.we[k] && !p.busy) sm[p.addr][k*8 +: 8] = p.data[k*8 +: 8];
  endtask

  task automatic cycle(input logic acs, input logic aoe, input logic [AW-1:0] aad,
                       input logic [3:0] awe, input logic [31:0] awd,
                       input logic bcs, input logic boe, input logic [AW-1:0] bad,
                       input logic [3:0] bwe, input logic [31:0] bwd);
    logic act_a, act_b, match, inc_a, inc_b, win_b, ba, bb;
    logic [3:0] va, vb;
    @(negedge clk);
    chk(tag, {28'b0, a_rvalid}, {28'b0, exp_va}, "port A rvalid");
    chk(tag, a_rdata, exp_ra, "port A rdata");
    chk(tag, {28'b0, b_rvalid}, {28'b0, exp_vb}, "port B rvalid");
    chk(tag, b_rdata, exp_rb, "port B rdata");
    a_cs_n = acs; a_oe_n = aoe; a_addr = aad; a_we_n = awe; a_wdata = awd;
    b_cs_n = bcs; b_oe_n = boe; b_addr = bad; b_we_n = bwe; b_wdata = bwd;
    #1;
    act_a = !acs; act_b = !bcs;
    match = act_a && act_b && (aad == bad);
    inc_a = h_act_a && (h_addr_a == aad);
    inc_b = h_act_b && (h_addr_b == bad);
    win_b = (h_match && inc_a && inc_b) ? h_win_b : (inc_b && !inc_a);
    ba = match && win_b;
    bb = match && !win_b;
    chk(tag, {31'b0, a_busy_n}, {31'b0, !ba}, "port A busy_n");
    chk(tag, {31'b0, b_busy_n}, {31'b0, !bb}, "port B busy_n");
    // read-first expectations
    va = {4{act_a && !aoe}} & awe;
    vb = {4{act_b && !boe}} & bwe;
    exp_va = va; exp_vb = vb;
    exp_ra = {sm[aad], mm[aad]} & lane_mask(va);
    exp_rb = {sm[bad], mm[bad]} & lane_mask(vb);
    // slave writes landing at this edge
    apply_slave(pa[D-1]);
    apply_slave(pb[D-1]);
    for (int i = D-1; i > 0; i--) begin pa[i] = pa[i-1]; pb[i] = pb[i-1]; end
    pa[0] = '{busy: ba, we: {2{act_a}} & ~awe[3:2], addr: aad, data: awd[31:16]};
    pb[0] = '{busy: bb, we: {2{act_b}} & ~bwe[3:2], addr: bad, data: bwd[31:16]};
    for (int k = 0; k < 2; k++) begin
      if (act_a && !ba && !awe[k]) mm[aad][k*8 +: 8] = awd[k*8 +: 8];
      if (act_b && !bb && !bwe[k]) mm[bad][k*8 +: 8] = bwd[k*8 +: 8];
    end
    h_act_a = act_a; h_act_b = act_b; h_addr_a = aad; h_addr_b = bad;
    h_match = match; h_win_b = match && win_b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1, 1, '0, 4'hF, '0, 1, 1, '0, 4'hF, '0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) begin mm[i] = '0; sm[i] = '0; end
    for (int i = 0; i < D; i++) begin pa[i] = '0; pb[i] = '0; end
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // reset state (R3, R4)
    chk("R3", {28'b0, a_rvalid}, 32'h0, "reset rvalid A");
    chk("R4", {30'b0, a_busy_n, b_busy_n}, 32'h3, "reset busy_n");
    rst_n = 1'b1;

    // R1: fill every word from port A, all lanes
    tag = "R1";
    for (int i = 0; i < NW; i++)
      cycle(0, 1, AW'(i), 4'h0, 32'hA000_0000 + 32'(i) * 32'h0101_0101, 1, 1, '0, 4'hF, '0);
    idle(D + 1);
    tag = "R2";
    for (int i = 0; i < NW; i++) cycle(0, 0, AW'(i), 4'hF, '0, 0, 0, AW'((i + 1) % NW), 4'hF, '0);

    // R1/R2: lower lane write with upper lane read on the same word
    tag = "R1";
    cycle(0, 0, 4'd3, 4'b1110, 32'h1111_22EE, 1, 1, '0, 4'hF, '0);
    cycle(0, 0, 4'd3, 4'hF, '0, 1, 1, '0, 4'hF, '0);

    // R3: deselected port strobes nothing
    tag = "R3";
    cycle(1, 0, 4'd4, 4'h0, 32'hDEAD_BEEF, 1, 0, 4'd4, 4'h0, 32'hBAD0_BAD0);
    idle(D + 1);
    cycle(0, 0, 4'd4, 4'hF, '0, 1, 1, '0, 4'hF, '0);

    // R5/R9: simultaneous arrival, both write -> A stored
    tag = "R9";
    cycle(0, 1, 4'd5, 4'h0, 32'hAAAA_AAAA, 0, 1, 4'd5, 4'h0, 32'hBBBB_BBBB);
    idle(D + 1);
    cycle(0, 0, 4'd5, 4'hF, '0, 1, 1, '0, 4'hF, '0);

    // R5/R6/R8: B holds address 6, A collides and is blocked, then completes
    tag = "R5";
    cycle(1, 1, '0, 4'hF, '0, 0, 0, 4'd6, 4'hF, '0);
    tag = "R6";
    cycle(0, 1, 4'd6, 4'h0, 32'h6666_6666, 0, 0, 4'd6, 4'hF, '0);
    cycle(0, 1, 4'd6, 4'h0, 32'h6666_6666, 0, 0, 4'd6, 4'hF, '0);
    tag = "R8";
    cycle(0, 1, 4'd6, 4'h0, 32'h6666_6666, 1, 1, '0, 4'hF, '0);
    idle(D + 1);
    cycle(0, 0, 4'd6, 4'hF, '0, 0, 0, 4'd7, 4'hF, '0);

    // R7: slave lanes lag the master lanes
    tag = "R7";
    cycle(0, 1, 4'd7, 4'h0, 32'h7777_7777, 1, 1, '0, 4'hF, '0);
    cycle(1, 1, '0, 4'hF, '0, 0, 0, 4'd7, 4'hF, '0);
    cycle(1, 1, '0, 4'hF, '0, 0, 0, 4'd7, 4'hF, '0);
    cycle(1, 1, '0, 4'hF, '0, 0, 0, 4'd7, 4'hF, '0);
    idle(1);

    // Constrained random on a narrow window
    tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2;
      r1 = $urandom; r2 = $urandom;
      cycle(r1[2:0] == 0, r1[3], AW'(r1[5:4]), r1[6] ? 4'hF : r1[11:8], $urandom,
            r2[2:0] == 0, r2[3], AW'(r2[5:4]), r2[6] ? 4'hF : r2[11:8], $urandom);
    end
    tag = "R2";
    idle(D + 2);
    finish_run();
  end
endmodule